// File: doc/BRIEF.md
# Programmable Down-Counter Timer with Prescaler

This block is an 8-bit interval timer for a small microcontroller. A down counter is loaded from a register write. It counts down once for each pulse from a 7-bit prescaler, and the prescaler picks one of eight power-of-two divide ratios. The prescaler takes its source ticks either from rising edges on an external timer pin or from a system clock enable that stands for the internal processor clock. The internal source can also be gated by the pin. The counter then advances only while the pin is high, which measures the width of a pulse.

When the counter reaches zero it sets a sticky request flag and keeps counting: it wraps to 0xFF and carries on. The flag and a mask bit sit in the control register. The interrupt output is a level that stays high until software clears the flag. Both registers are reached over a simple synchronous bus with one address bit. Reads have no side effects.

Top module: `dcount_timer`

## Requirements
- R1: After reset the data register reads 0xFF, the control register reads 0x00 and irq_out is low.
- R2: Control bits 2:0 hold a tap number k. The counter decrements once per 2^k source ticks, counted from the last prescaler clear (k = 0 gives one decrement per tick).
- R3: Writing the control register with bit 3 set clears the prescaler, so the next decrement needs a full 2^k ticks. Bit 3 always reads 0.
- R4: A decrement that brings the counter from 1 to 0 sets the request flag, control bit 7. The flag stays set until a control write puts 0 in bit 7. Writing 1 to bit 7 leaves the flag as it is.
- R5: Control bit 6 is the mask. irq_out is high exactly while the flag is set and the mask is clear, and it stays high until the flag is cleared.
- R6: Clearing the flag with a control write while the mask is set produces no pulse on irq_out.
- R7: A decrement from 0 gives 0xFF and counting continues. Reading either register never alters or stalls the count.
- R8: With control bit 4 = 1 (external source), each rising edge of tmr_pin counts as one source tick. The pin passes through a two-flop synchronizer first, and clk_en is ignored.
- R9: With control bit 4 = 0, each cycle with clk_en high is a source tick. If control bit 5 = 1 as well, such a cycle only counts while the synchronized tmr_pin is high.
- R10: A data write in the same cycle as a decrement loads the written value. Loading 0 does not set the flag; the flag is set only when a later decrement reaches zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_en | input | 1 | Internal count enable (processor clock phase) |
| tmr_pin | input | 1 | External timer pin, asynchronous |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | 0 = counter data register, 1 = control register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register (combinational) |
| irq_out | output | 1 | Level-sensitive interrupt request |

## Verification
The assertions take for granted that the timer pin changes no faster than the synchronizer can follow. Each high and each low phase must last at least two clock cycles, so every rising edge gives exactly one tick. The stimulus keeps each pin level for three cycles or more. It holds clk_en low while it reprograms the block, so every measured window starts from a cleared prescaler and a known count. The only deliberate overlap of a load with a decrement is the dedicated load-priority test.

// File: rtl/dtm_pkg.sv
package dtm_pkg;
  localparam int CNT_W = 8;
  localparam int PRE_W = 7;
  localparam int SEL_W = 3;

  typedef struct packed {
    logic             flag;
    logic             mask;
    logic             gate;
    logic             ext;
    logic             pclr;
    logic [SEL_W-1:0] sel;
  } ctrl_t;

  // low-order prescaler bits that must all be one for tap k to fire
  function automatic logic [PRE_W-1:0] tap_mask(input logic [SEL_W-1:0] k);
    logic [PRE_W:0] one_hot;
    one_hot = (PRE_W+1)'(1) << k;
    return PRE_W'(one_hot - 1'b1);
  endfunction

  function automatic logic tap_hit(input logic [PRE_W-1:0] cnt,
                                   input logic [SEL_W-1:0] k);
    return (cnt & tap_mask(k)) == tap_mask(k);
  endfunction
endpackage

// File: rtl/dtm_edge_sync.sv
module dtm_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic pin_lvl,
  output logic pin_rise
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-1:0], pin};
  end

  assign pin_lvl  = chain[STAGES-1];
  assign pin_rise = chain[STAGES-1] & ~chain[STAGES];

  assert_rise_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pin_rise |=> !pin_rise);
endmodule

// File: rtl/dtm_prescaler.sv
module dtm_prescaler
  import dtm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_tick,
  input  logic             clr,
  input  logic [SEL_W-1:0] sel,
  output logic             fire
);
  logic [PRE_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (clr)      cnt <= '0;
    else if (src_tick) cnt <= cnt + 1'b1;
  end

  assign fire = src_tick & ~clr & tap_hit(cnt, sel);

  assert_prescale_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt == '0);
  assert_no_tick_no_fire_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !src_tick |-> !fire);
endmodule

// File: rtl/dtm_downcount.sv
module dtm_downcount #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic [W-1:0] cnt,
  output logic         zero_evt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '1;
    else if (load) cnt <= load_val;
    else if (dec)  cnt <= cnt - 1'b1;
  end

  assign zero_evt = dec & ~load & (cnt == W'(1));

  assert_load_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cnt == $past(load_val));
  assert_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !load && cnt == '0) |=> cnt == '1);
  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!dec && !load) |=> $stable(cnt));
endmodule

// File: rtl/dcount_timer.sv
module dcount_timer
  import dtm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_en,
  input  logic             tmr_pin,
  input  logic             bus_wr,
  input  logic             bus_addr,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  output logic             irq_out
);
  ctrl_t            ctrl_q;
  ctrl_t            wr_fields;
  logic             wr_data, wr_ctrl;
  logic             pin_lvl, pin_rise;
  logic             src_tick, pre_fire, pre_clr, zero_evt;
  logic [CNT_W-1:0] count;

  assign wr_fields = ctrl_t'(bus_wdata);
  assign wr_data   = bus_wr & ~bus_addr;
  assign wr_ctrl   = bus_wr &  bus_addr;
  assign pre_clr   = wr_ctrl & wr_fields.pclr;

  dtm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(tmr_pin),
    .pin_lvl(pin_lvl), .pin_rise(pin_rise));

  assign src_tick = ctrl_q.ext ? pin_rise
                               : (clk_en & (~ctrl_q.gate | pin_lvl));

  dtm_prescaler u_pre (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .clr(pre_clr),
    .sel(ctrl_q.sel), .fire(pre_fire));

  dtm_downcount #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(wr_data), .load_val(bus_wdata),
    .dec(pre_fire), .cnt(count), .zero_evt(zero_evt));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (wr_ctrl) begin
      ctrl_q.sel  <= wr_fields.sel;
      ctrl_q.ext  <= wr_fields.ext;
      ctrl_q.gate <= wr_fields.gate;
      ctrl_q.mask <= wr_fields.mask;
      ctrl_q.flag <= zero_evt | (ctrl_q.flag & wr_fields.flag);
    end else begin
      ctrl_q.flag <= ctrl_q.flag | zero_evt;
    end
  end

  assign bus_rdata = bus_addr ? {ctrl_q.flag, ctrl_q.mask, ctrl_q.gate, ctrl_q.ext,
                                 1'b0, ctrl_q.sel}
                              : count;
  assign irq_out   = ctrl_q.flag & ~ctrl_q.mask;

  assert_flag_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    zero_evt |=> ctrl_q.flag);
  assert_flag_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.flag && !wr_ctrl) |=> ctrl_q.flag);
  assert_mask_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.mask |-> !irq_out);
  assert_irq_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out && !wr_ctrl) |=> irq_out);
  assert_masked_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && wr_fields.mask && ctrl_q.mask) |=> !irq_out);
  assert_ext_ignores_en_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.ext && !pin_rise) |-> !pre_fire);
  assert_gate_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q.ext && ctrl_q.gate && !pin_lvl) |-> !pre_fire);
endmodule

// File: tb/dcount_timer_tb.sv
module dcount_timer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clk_en = 1'b0;
  logic       tmr_pin = 1'b0;
  logic       bus_wr = 1'b0;
  logic       bus_addr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       irq_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dcount_timer u_dut (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .tmr_pin(tmr_pin),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_out(irq_out));

  // vector table: tap number, load value, clk_en cycles
  localparam int NV = 8;
  localparam int VSEL [NV] = '{0, 0, 0, 1, 3, 7, 2, 4};
  localparam int VLD  [NV] = '{10, 3, 2, 20, 5, 4, 0, 1};
  localparam int VWIN [NV] = '{5, 3, 5, 9, 40, 300, 8, 17};

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic run(input int w);
    clk_en = 1'b1;
    repeat (w) @(negedge clk);
    clk_en = 1'b0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rd(1'b0, v); check("R1 data reset", v, 8'hFF);
    rd(1'b1, v); check("R1 ctrl reset", v, 8'h00);
    check("R1 irq reset", irq_out, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // table of prescaler and count vectors (R2, R4, R7, R10)
    for (int i = 0; i < NV; i++) begin
      int d, ec, ef;
      wr(1'b1, 8'h48 | 8'(VSEL[i]));   // mask set, prescaler clear, flag cleared
      wr(1'b0, 8'(VLD[i]));
      run(VWIN[i]);
      d  = VWIN[i] >> VSEL[i];
      ec = (VLD[i] - d) & 255;
      ef = ((VLD[i] != 0 && d >= VLD[i]) || d >= VLD[i] + 256) ? 1 : 0;
      rd(1'b0, v); check($sformatf("R2/R7 vector %0d count", i), v, ec);
      rd(1'b1, v); check($sformatf("R4/R10 vector %0d flag", i), v[7], ef);
      check($sformatf("R5 vector %0d masked irq", i), irq_out, 0);
      check($sformatf("R3 vector %0d clear bit reads 0", i), v[3], 0);
    end

    // R6: clear flag while masked, no irq pulse
    wr(1'b1, 8'h48); wr(1'b0, 8'd2); run(2);
    rd(1'b1, v); check("R4 flag set at zero", v[7], 1);
    bus_wr = 1'b1; bus_addr = 1'b1; bus_wdata = 8'h40;
    @(posedge clk); #1 check("R6 irq after masked clear", irq_out, 0);
    @(negedge clk); bus_wr = 1'b0;
    rd(1'b1, v); check("R6 flag cleared", v[7], 0);
    check("R6 irq stays low", irq_out, 0);

    // R5: unmask with flag set, level held, then cleared
    wr(1'b0, 8'd1); run(1);
    wr(1'b1, 8'h80);                 // unmask, write 1 keeps flag
    check("R5 irq asserted", irq_out, 1);
    repeat (5) @(negedge clk);
    check("R5 irq level holds", irq_out, 1);
    rd(1'b1, v); check("R4 write one keeps flag", v[7], 1);
    wr(1'b1, 8'h00);
    check("R5 irq drops on clear", irq_out, 0);

    // R7: wrap past zero and reads do not disturb count
    wr(1'b1, 8'h48); wr(1'b0, 8'd1); run(3);
    rd(1'b0, v); check("R7 wrap to 0xFE", v, 8'hFE);
    repeat (4) begin rd(1'b0, v); rd(1'b1, v); @(negedge clk); end
    rd(1'b0, v); check("R7 reads leave count", v, 8'hFE);

    // R3: prescaler clear restarts the divide
    wr(1'b1, 8'h49); wr(1'b0, 8'd9); run(1);
    rd(1'b0, v); check("R3 half divide", v, 9);
    wr(1'b1, 8'h49); run(1);
    rd(1'b0, v); check("R3 clear restarts", v, 9);
    run(1);
    rd(1'b0, v); check("R3 full divide after clear", v, 8);

    // R8: external pin edges, clk_en ignored
    wr(1'b1, 8'h58); wr(1'b0, 8'd50);
    clk_en = 1'b1;
    repeat (3) begin
      tmr_pin = 1'b1; repeat (3) @(negedge clk);
      tmr_pin = 1'b0; repeat (3) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    clk_en = 1'b0;
    rd(1'b0, v); check("R8 three pin edges", v, 47);

    // R9: internal source gated by pin level
    wr(1'b1, 8'h68); wr(1'b0, 8'd100);
    run(10);
    rd(1'b0, v); check("R9 gated while pin low", v, 100);
    tmr_pin = 1'b1; repeat (4) @(negedge clk);
    run(10);
    rd(1'b0, v); check("R9 counts while pin high", v, 90);
    tmr_pin = 1'b0; repeat (4) @(negedge clk);
    wr(1'b1, 8'h48); run(6);
    rd(1'b0, v); check("R9 ungated counts", v, 84);

    // R10: load beats a simultaneous decrement
    clk_en = 1'b1;
    bus_wr = 1'b1; bus_addr = 1'b0; bus_wdata = 8'h40;
    @(negedge clk); bus_wr = 1'b0;
    rd(1'b0, v); check("R10 load wins", v, 8'h40);
    @(negedge clk);
    clk_en = 1'b0;
    rd(1'b0, v); check("R10 decrement after load", v, 8'h3F);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule